// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block decides which control-store word runs next. Each cycle it takes the fields of the microinstruction now executing and picks the next address. The choices are the instruction's own jump field, the entry on top of a small return-address stack, or a prepared "next-next" address register. Around that choice sit three extra mechanisms: subroutine call and return through the stack, a conditional skip that forces one address bit from the tested condition, and a conditional trap that sends control to the jump field.

The prepared address register is loaded every cycle. It takes either the jump field with a middle nibble replaced by a dispatch code, or the address just chosen plus one. Later instructions can then branch to it. A halt strobe lets the current instruction finish, then freezes the sequencer until reset. The condition bit, the dispatch code and the control store itself come from outside the block.

Top module: `useq_sequencer`

## Requirements
- R1: Reset (synchronous, active high) sets the current address, the prepared address, the stack pointer and every stack entry to zero, and clears the halted flag.
- R2: With no trap taken, address source 0 loads the current address from the jump field. Source 3 is reserved and also takes the jump field.
- R3: Address source 1 loads the current address from the stack entry selected by the stack pointer before this cycle's pop or push.
- R4: Address source 2 loads the current address from the prepared address register.
- R5: With prepared-select 0, the prepared register loads the jump field with bits 11:8 replaced by the 4-bit dispatch code.
- R6: With prepared-select 1, the prepared register loads the newly chosen current address plus one, modulo 2^14.
- R7: Sequencer function 1 (call) advances the stack pointer by one and writes the current address plus one into the entry it now points to. Function 2 has no effect on the stack.
- R8: Sequencer function 3 (return) moves the stack pointer back by one.
- R9: Condition function 1 (skip) replaces bit 12 of the selected address with the inverse of the condition bit and leaves every other bit unchanged.
- R10: Condition function 2 with the condition true, or function 3 with it false, is a trap. The current address becomes the jump field, whatever the address source.
- R11: Condition function 2 with the condition false, function 3 with it true, and function 0 leave the selected address unchanged.
- R12: A halt strobe lets its own instruction complete and then raises the halted flag. While halted, the current address, the prepared address and the stack ignore all inputs until reset.
- R13: The stack holds 16 entries and its pointer wraps modulo 16. A 17th call without a return overwrites the entry written by the first call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| naf_i | input | 14 | Jump field of the current microinstruction |
| cpc_sel_i | input | 2 | Address source: 0 jump field, 1 stack top, 2 prepared register, 3 reserved |
| npc_sel_i | input | 1 | Prepared-register load: 0 dispatch splice, 1 chosen address plus one |
| seq_fn_i | input | 2 | Sequencer function: 0 none, 1 call, 2 none, 3 return |
| cond_fn_i | input | 2 | Condition use: 0 ignore, 1 skip, 2 trap if true, 3 trap if false |
| cond_i | input | 1 | Selected condition bit |
| dispatch_i | input | 4 | Dispatch code spliced into bits 11:8 |
| halt_i | input | 1 | Stop after this instruction |
| cpc_o | output | 14 | Current microprogram address |
| halted_o | output | 1 | Sequencer is stopped |

## Verification
A vector table walks all four address sources in turn. Each pattern uses jump-field, stack and prepared values that differ, so a wrong source choice shows up as a wrong address. Skip rows include one where bit 12 is set by a false condition and one where a set bit 12 is cleared by a true condition. Trap rows pair each trap polarity with a condition that does not trap, and one trap is taken while the stack is the selected source. A seventeen-deep call burst followed by seventeen returns tells a wrapping sixteen-entry stack from a deeper or saturating one. A halt test drives changing fields after the stop to show that nothing moves.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UADDR_W  = 14;
  localparam int DISP_W   = 4;
  localparam int DISP_LSB = 8;
  localparam int SKIP_BIT = 12;

  typedef logic [UADDR_W-1:0] uaddr_t;

  typedef enum logic [1:0] {
    SRC_JUMP  = 2'd0,
    SRC_STACK = 2'd1,
    SRC_PREP  = 2'd2,
    SRC_RSVD  = 2'd3
  } addr_src_e;

  typedef enum logic [1:0] {
    SEQ_NONE  = 2'd0,
    SEQ_CALL  = 2'd1,
    SEQ_IDLE  = 2'd2,
    SEQ_RET   = 2'd3
  } seq_fn_e;

  typedef enum logic [1:0] {
    CFN_IGNORE = 2'd0,
    CFN_SKIP   = 2'd1,
    CFN_TRAP_T = 2'd2,
    CFN_TRAP_F = 2'd3
  } cond_fn_e;

  function automatic uaddr_t addr_inc(uaddr_t a);
    return a + uaddr_t'(1);
  endfunction

  function automatic logic trap_taken(cond_fn_e f, logic c);
    return (f == CFN_TRAP_T && c) || (f == CFN_TRAP_F && !c);
  endfunction

  function automatic uaddr_t force_skip(uaddr_t a, logic c);
    uaddr_t r;
    r = a;
    r[SKIP_BIT] = ~c;
    return r;
  endfunction

  function automatic uaddr_t splice_dispatch(uaddr_t jump, logic [DISP_W-1:0] d);
    uaddr_t r;
    r = jump;
    r[DISP_LSB +: DISP_W] = d;
    return r;
  endfunction
endpackage

// File: rtl/useq_ctl_stack.sv
module useq_ctl_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] tos
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_up;
  logic [PTR_W-1:0] sp_down;
  logic [WIDTH-1:0] mem_q [DEPTH];

  assign sp_up   = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_down = (sp_q == '0) ? LAST : sp_q - 1'b1;
  assign tos     = mem_q[sp_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (en) begin
      if (push) begin
        sp_q <= sp_up;
        mem_q[sp_up] <= push_data;
      end else if (pop) begin
        sp_q <= sp_down;
      end
    end
  end

  // a call leaves its data on top
  assert_call_lands_on_top_R7: assert property (@(posedge clk) disable iff (rst)
    (en && push) |=> tos == $past(push_data));

  // a return moves the pointer back one slot (modulo depth)
  assert_return_steps_back_R8: assert property (@(posedge clk) disable iff (rst)
    (en && pop && !push) |=> (($past(sp_q) == '0) ? (sp_q == LAST) : (sp_q == $past(sp_q) - 1'b1)));
endmodule

// File: rtl/useq_addr_select.sv
module useq_addr_select
  import useq_pkg::*;
(
  input  addr_src_e src,
  input  cond_fn_e  cfn,
  input  logic      cond,
  input  uaddr_t    jump,
  input  uaddr_t    stack_top,
  input  uaddr_t    prep,
  output uaddr_t    next_addr,
  output logic      trap_hit,
  output logic      skip_hit
);
  uaddr_t base;

  always_comb begin
    unique case (src)
      SRC_STACK: base = stack_top;
      SRC_PREP:  base = prep;
      default:   base = jump;
    endcase
  end

  assign trap_hit = trap_taken(cfn, cond);
  assign skip_hit = (cfn == CFN_SKIP);

  always_comb begin
    if (trap_hit)      next_addr = jump;
    else if (skip_hit) next_addr = force_skip(base, cond);
    else               next_addr = base;
  end

  always_comb begin
    assert_trap_skip_exclusive_R10: assert (!(trap_hit && skip_hit));
  end
endmodule

// File: rtl/useq_npc_calc.sv
module useq_npc_calc
  import useq_pkg::*;
(
  input  logic              npc_sel,
  input  uaddr_t            jump,
  input  logic [DISP_W-1:0] dispatch,
  input  uaddr_t            next_addr,
  output uaddr_t            npc_next
);
  assign npc_next = npc_sel ? addr_inc(next_addr) : splice_dispatch(jump, dispatch);
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [UADDR_W-1:0]  naf_i,
  input  logic [1:0]          cpc_sel_i,
  input  logic                npc_sel_i,
  input  logic [1:0]          seq_fn_i,
  input  logic [1:0]          cond_fn_i,
  input  logic                cond_i,
  input  logic [DISP_W-1:0]   dispatch_i,
  input  logic                halt_i,
  output logic [UADDR_W-1:0]  cpc_o,
  output logic                halted_o
);
  uaddr_t   cpc_q;
  uaddr_t   npc_q;
  logic     halted_q;
  uaddr_t   stack_top;
  uaddr_t   next_addr;
  uaddr_t   npc_next;
  logic     trap_hit;
  logic     skip_hit;
  logic     advance;
  logic     do_call;
  logic     do_ret;
  seq_fn_e  seq_fn;

  assign seq_fn  = seq_fn_e'(seq_fn_i);
  assign advance = !halted_q;
  assign do_call = (seq_fn == SEQ_CALL);
  assign do_ret  = (seq_fn == SEQ_RET);

  useq_ctl_stack #(.DEPTH(STACK_DEPTH), .WIDTH(UADDR_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .en        (advance),
    .push      (do_call),
    .pop       (do_ret),
    .push_data (addr_inc(cpc_q)),
    .tos       (stack_top)
  );

  useq_addr_select u_select (
    .src       (addr_src_e'(cpc_sel_i)),
    .cfn       (cond_fn_e'(cond_fn_i)),
    .cond      (cond_i),
    .jump      (naf_i),
    .stack_top (stack_top),
    .prep      (npc_q),
    .next_addr (next_addr),
    .trap_hit  (trap_hit),
    .skip_hit  (skip_hit)
  );

  useq_npc_calc u_npc (
    .npc_sel   (npc_sel_i),
    .jump      (naf_i),
    .dispatch  (dispatch_i),
    .next_addr (next_addr),
    .npc_next  (npc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpc_q    <= '0;
      npc_q    <= '0;
      halted_q <= 1'b0;
    end else if (advance) begin
      cpc_q    <= next_addr;
      npc_q    <= npc_next;
      halted_q <= halt_i;
    end
  end

  assign cpc_o    = cpc_q;
  assign halted_o = halted_q;

  assert_trap_vectors_R10: assert property (@(posedge clk) disable iff (rst)
    (advance && trap_hit) |=> cpc_q == $past(naf_i));

  assert_skip_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (advance && skip_hit) |=> cpc_q[SKIP_BIT] == !$past(cond_i));

  assert_prep_source_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !trap_hit && !skip_hit && cpc_sel_i == 2'd2) |=> cpc_q == $past(npc_q));

  assert_halt_takes_R12: assert property (@(posedge clk) disable iff (rst)
    (advance && halt_i) |=> halted_q);

  assert_halt_freezes_R12: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && $stable(cpc_q) && $stable(npc_q)));
endmodule

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] naf = '0;
  logic [1:0]  cpc_sel = '0;
  logic        npc_sel = 1'b0;
  logic [1:0]  seq_fn = '0;
  logic [1:0]  cond_fn = '0;
  logic        cond = 1'b0;
  logic [3:0]  dispatch = '0;
  logic        halt = 1'b0;
  logic [13:0] cpc;
  logic        halted;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  useq_sequencer uut (
    .clk(clk), .rst(rst), .naf_i(naf), .cpc_sel_i(cpc_sel), .npc_sel_i(npc_sel),
    .seq_fn_i(seq_fn), .cond_fn_i(cond_fn), .cond_i(cond), .dispatch_i(dispatch),
    .halt_i(halt), .cpc_o(cpc), .halted_o(halted)
  );

  // {cpc_sel, npc_sel, seq_fn, cond_fn, cond, dispatch, jump, expected address}
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 4'h5, 14'h0123, 14'h0123},  // R2 jump, R5 splice
    {2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 4'h0, 14'h0200, 14'h0523},  // R4 prepared, R5 seen
    {2'd2, 1'b1, 2'd1, 2'd0, 1'b0, 4'h0, 14'h0000, 14'h0524},  // R7 call, R6 plus one
    {2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 4'h0, 14'h0040, 14'h1040},  // R9 false sets bit 12
    {2'd0, 1'b0, 2'd0, 2'd1, 1'b1, 4'h3, 14'h1077, 14'h0077},  // R9 true clears bit 12
    {2'd1, 1'b1, 2'd3, 2'd0, 1'b0, 4'h0, 14'h0333, 14'h0524},  // R3 stack top, R8 return
    {2'd2, 1'b1, 2'd0, 2'd2, 1'b1, 4'h0, 14'h2A5A, 14'h2A5A},  // R10 trap on true
    {2'd2, 1'b1, 2'd0, 2'd3, 1'b1, 4'h0, 14'h0111, 14'h2A5B},  // R11 no trap, R6
    {2'd1, 1'b1, 2'd0, 2'd3, 1'b0, 4'h0, 14'h3FFF, 14'h3FFF},  // R10 trap on false over stack
    {2'd2, 1'b0, 2'd0, 2'd2, 1'b0, 4'hF, 14'h0005, 14'h0000},  // R11, R6 wrap to zero
    {2'd2, 1'b1, 2'd0, 2'd1, 1'b0, 4'h0, 14'h0000, 14'h1F05},  // R9 on prepared, R5
    {2'd3, 1'b0, 2'd0, 2'd0, 1'b0, 4'h0, 14'h0ABC, 14'h0ABC}   // R2 reserved source
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cs, input logic ns, input logic [1:0] sf,
                       input logic [1:0] cf, input logic c, input logic [3:0] d,
                       input logic [13:0] j, input logic h);
    cpc_sel = cs; npc_sel = ns; seq_fn = sf; cond_fn = cf;
    cond = c; dispatch = d; naf = j; halt = h;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cpc_sel = '0; npc_sel = 1'b0; seq_fn = '0; cond_fn = '0;
    cond = 1'b0; dispatch = '0; naf = '0; halt = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  function automatic logic [13:0] wrap_expect(input int slot);
    if (slot == 1) return 14'h201;
    if (slot == 0) return 14'h1F1;
    return 14'(32'h100 + 32'h10 * (slot - 1) + 1);
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 address", cpc, 14'h0000);
    check("R1 halted", {13'b0, halted}, 14'h0000);
    drive(2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 4'h0, 14'h0000, 1'b0);
    check("R1 prepared cleared", cpc, 14'h0000);
    drive(2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 4'h0, 14'h0000, 1'b0);
    check("R1 stack cleared", cpc, 14'h0000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][39:38], VEC[i][37], VEC[i][36:35], VEC[i][34:33], VEC[i][32],
            VEC[i][31:28], VEC[i][27:14], 1'b0);
      check($sformatf("vector %0d", i), cpc, VEC[i][13:0]);
    end

    // R1 mid-run reset
    do_reset();
    check("R1 reset again", cpc, 14'h0000);

    // R13: 17 calls then 17 returns through a 16-entry stack
    for (int k = 1; k <= 17; k++) begin
      drive(2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 4'h0, 14'(32'h100 + 32'h10 * k), 1'b0);
      check("R7 call sequence", cpc, 14'(32'h100 + 32'h10 * k));
    end
    for (int k = 1; k <= 17; k++) begin
      int slot;
      slot = ((2 - k) % 16 + 16) % 16;
      drive(2'd1, 1'b0, 2'd3, 2'd0, 1'b0, 4'h0, 14'h0000, 1'b0);
      check((k == 17) ? "R13 wrap overwrite" : "R8 return order", cpc, wrap_expect(slot));
    end

    // R12 halt
    do_reset();
    drive(2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 4'h2, 14'h0100, 1'b1);
    check("R12 halting instruction completes", cpc, 14'h0100);
    check("R12 halted raised", {13'b0, halted}, 14'h0001);
    drive(2'd0, 1'b1, 2'd1, 2'd0, 1'b0, 4'h0, 14'h0200, 1'b0);
    check("R12 jump ignored", cpc, 14'h0100);
    drive(2'd2, 1'b0, 2'd0, 2'd2, 1'b1, 4'h0, 14'h0300, 1'b0);
    check("R12 trap ignored", cpc, 14'h0100);
    check("R12 still halted", {13'b0, halted}, 14'h0001);
    do_reset();
    check("R12 reset releases", {13'b0, halted}, 14'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule